// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps the coherence state of every line of a small direct-mapped private cache attached to a shared snooping bus. Each line holds a tag and one of four states: Invalid, Shared (clean, other copies may exist), Exclusive (clean, the only copy) or Modified (dirty, the only copy). Processor loads and stores are checked against the line at the address index. A hit that needs no permission completes in the same cycle. Any other access raises a bus request and completes when the bus grant arrives. Bus commands and snoop commands use the same 2-bit code: 0 idle, 1 read, 2 read-for-ownership, 3 flush.

While another cache owns the bus, the block watches the snoop port. During a foreign read it drives the wired-OR shared line if it holds a valid copy. It writes back dirty data and downgrades or invalidates its own copy as the protocol requires. Snoops always take precedence over a waiting local request, and the bus decision is recomputed every cycle from the current line state. A copy lost to a snoop during a stall therefore turns the pending access into a miss. The arbiter must never give a grant in a cycle that carries a snoop.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid: busReq, procDone, sharedOut and snoopFlush are 0, and a snooped read of any address drives sharedOut 0.
- R2: A load to a line that is Invalid or holds another tag raises busReq with busCmd 1 (read) and busAddr equal to procAddr. In the grant cycle procDone is 1, and the line becomes Exclusive (procState 2) if sharedIn is 0 in that cycle, or Shared (procState 1) if it is 1.
- R3: In a cycle with snoopValid 1, snoopCmd 1 and a snoopAddr that matches a valid line (state 1, 2 or 3), sharedOut is 1 in that same cycle.
- R4: A store that hits an Exclusive line completes in the same cycle with no bus request, and the line becomes Modified (procState 3).
- R5: A store to an Invalid line, a line with another tag, or a Shared line raises busCmd 2 (read-for-ownership) at procAddr. In the grant cycle it completes with procState 3.
- R6: A snooped read that hits a Modified line drives snoopFlush 1 in that cycle and leaves the line Shared. A snooped read that hits an Exclusive line leaves it Shared with snoopFlush 0.
- R7: A snooped read-for-ownership that hits a valid line makes it Invalid. snoopFlush is 1 in that cycle only if the line was Modified.
- R8: A load that hits a Shared, Exclusive or Modified line completes in the same cycle with no bus request, and procState reports the unchanged state.
- R9: In a cycle with snoopValid 1, procDone is 0. The snoop's effect on the line is applied first, and the request that follows is decided from the updated state: a copy invalidated or downgraded by the snoop is handled as a miss or an upgrade.
- R10: When a miss maps onto a Modified line with another tag, the block first issues busCmd 3 (flush) at the victim's address ({stored tag, index}). After that grant the line is Invalid and the fill request for procAddr follows.
- R11: A snoop whose tag does not match the stored tag, or whose command is 3 (flush), leaves sharedOut and snoopFlush at 0 and leaves the line state unchanged.
- R12: procState, valid while procDone is 1, gives the line's state after the access using the code 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| procReq | input | 1 | Processor access valid; held until procDone |
| procWrite | input | 1 | 1 for a store, 0 for a load |
| procAddr | input | ADDR_W | Line address of the access |
| procDone | output | 1 | Access completes this cycle |
| procState | output | 2 | Line state after the access |
| busReq | output | 1 | Bus request |
| busCmd | output | 2 | Requested command: 1 read, 2 read-for-ownership, 3 flush |
| busAddr | output | ADDR_W | Address of the requested transaction |
| busGrant | input | 1 | Grant; the granted transaction happens in this cycle |
| sharedIn | input | 1 | Wired-OR shared line, sampled in the grant cycle of a read |
| sharedOut | output | 1 | This cache's drive onto the shared line |
| snoopValid | input | 1 | A foreign transaction is on the bus |
| snoopCmd | input | 2 | Command of the foreign transaction |
| snoopAddr | input | ADDR_W | Address of the foreign transaction |
| snoopFlush | output | 1 | This cache supplies dirty data for the snooped line |

## Verification
The bench aims at the cases where the order of events matters. One is a store to an Exclusive line in the same cycle as a snooped read of it. A design that lets the processor win would finish the store silently and leave a dirty line that another cache believes it shares. Another is a victim writeback that is still waiting when a foreign read-for-ownership takes the victim. A design that latched its decision would write back stale data a second time instead of going straight to the fill. Further checks cover the fill state under both values of the shared line, snoops whose tag does not match, and snooped flushes, which must have no effect. They also check that a dirty line hit by a snoop flushes only when it is Modified, and that a line downgraded by a snoop returns to the bus on the next store.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_READX = 2'd2,
    CMD_FLUSH = 2'd3
  } busCmd_t;

  // strobes from control to the tag/state store
  typedef struct packed {
    logic       procWr;
    logic       procSetTag;
    lineState_t procNew;
    logic       snoopWr;
    lineState_t snoopNew;
  } storeStrobe_t;

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           procAddr,
  input  logic [ADDR_W-1:0]           snoopAddr,
  input  storeStrobe_t                strb,
  output lineState_t                  procLineState,
  output logic [ADDR_W-IDX_W-1:0]     procLineTag,
  output logic                        procTagHit,
  output lineState_t                  snoopLineState,
  output logic                        snoopTagHit
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] procIdx, snoopIdx;
  logic [TAG_W-1:0] procTag, snoopTag;

  assign procIdx  = procAddr[IDX_W-1:0];
  assign procTag  = procAddr[ADDR_W-1:IDX_W];
  assign snoopIdx = snoopAddr[IDX_W-1:0];
  assign snoopTag = snoopAddr[ADDR_W-1:IDX_W];

  lineState_t       stArr  [LINES];
  logic [TAG_W-1:0] tagArr [LINES];

  // one register set per line; the snoop port wins a same-line collision
  for (genvar g = 0; g < LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stArr[g]  <= ST_I;
        tagArr[g] <= '0;
      end else if (strb.snoopWr && snoopIdx == IDX_W'(g)) begin
        stArr[g] <= strb.snoopNew;
      end else if (strb.procWr && procIdx == IDX_W'(g)) begin
        stArr[g] <= strb.procNew;
        if (strb.procSetTag) tagArr[g] <= procTag;
      end
    end
  end

  assign procLineState  = stArr[procIdx];
  assign procLineTag    = tagArr[procIdx];
  assign procTagHit     = (tagArr[procIdx] == procTag) && (stArr[procIdx] != ST_I);
  assign snoopLineState = stArr[snoopIdx];
  assign snoopTagHit    = (tagArr[snoopIdx] == snoopTag) && (stArr[snoopIdx] != ST_I);

  // a snoop-driven state change is visible on the next cycle
  assert_snoop_update_lands_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.snoopWr |=> stArr[$past(snoopIdx)] == $past(strb.snoopNew));

  // a processor-driven update lands unless a snoop took the same line
  assert_proc_update_lands_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.procWr && !(strb.snoopWr && snoopIdx == procIdx))
      |=> stArr[$past(procIdx)] == $past(strb.procNew));

endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         procReq,
  input  logic         procWrite,
  input  lineState_t   lineState,
  input  logic         tagHit,
  input  logic         busGrant,
  input  logic         sharedIn,
  input  logic         snoopValid,
  input  logic [1:0]   snoopCmd,
  input  lineState_t   snoopState,
  input  logic         snoopHit,
  output logic         busReq,
  output busCmd_t      busCmd,
  output logic         victimSel,
  output logic         procDone,
  output lineState_t   procResState,
  output logic         sharedOut,
  output logic         snoopFlush,
  output storeStrobe_t strb
);

  busCmd_t    snoopOp;
  busCmd_t    needCmd;
  lineState_t grantState;
  logic       grantOk;

  assign snoopOp = busCmd_t'(snoopCmd);

  // snoop response: same-cycle drive, state update at the edge
  always_comb begin
    sharedOut     = 1'b0;
    snoopFlush    = 1'b0;
    strb.snoopWr  = 1'b0;
    strb.snoopNew = ST_I;
    if (snoopValid && snoopHit) begin
      unique case (snoopOp)
        CMD_READ: begin
          sharedOut  = 1'b1;
          snoopFlush = (snoopState == ST_M);
          if (snoopState == ST_M || snoopState == ST_E) begin
            strb.snoopWr  = 1'b1;
            strb.snoopNew = ST_S;
          end
        end
        CMD_READX: begin
          snoopFlush    = (snoopState == ST_M);
          strb.snoopWr  = 1'b1;
          strb.snoopNew = ST_I;
        end
        default: ;
      endcase
    end
  end

  // processor decision, recomputed every cycle from the current line state
  always_comb begin
    needCmd    = CMD_IDLE;
    victimSel  = 1'b0;
    grantState = ST_I;
    if (tagHit) begin
      if (procWrite && lineState == ST_S) begin
        needCmd    = CMD_READX;
        grantState = ST_M;
      end
    end else if (lineState == ST_M) begin
      needCmd    = CMD_FLUSH;
      victimSel  = 1'b1;
      grantState = ST_I;
    end else if (procWrite) begin
      needCmd    = CMD_READX;
      grantState = ST_M;
    end else begin
      needCmd    = CMD_READ;
      grantState = sharedIn ? ST_S : ST_E;
    end
  end

  assign busReq  = procReq && (needCmd != CMD_IDLE);
  assign busCmd  = busReq ? needCmd : CMD_IDLE;
  assign grantOk = busReq && busGrant && !snoopValid;

  always_comb begin
    procDone        = 1'b0;
    procResState    = lineState;
    strb.procWr     = 1'b0;
    strb.procSetTag = 1'b0;
    strb.procNew    = lineState;
    if (procReq && !snoopValid) begin
      if (needCmd == CMD_IDLE) begin
        procDone = 1'b1;
        if (procWrite) begin
          procResState = ST_M;
          strb.procWr  = (lineState == ST_E);
          strb.procNew = ST_M;
        end
      end else if (grantOk) begin
        strb.procWr  = 1'b1;
        strb.procNew = grantState;
        if (needCmd != CMD_FLUSH) begin
          procDone        = 1'b1;
          procResState    = grantState;
          strb.procSetTag = 1'b1;
        end
      end
    end
  end

  assert_silent_upgrade_R4: assert property (@(posedge clk) disable iff (!rstN)
    (procReq && procWrite && tagHit && lineState == ST_E && !snoopValid)
      |-> (procDone && !busReq && procResState == ST_M));

  assert_read_hit_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (procReq && !procWrite && tagHit && !snoopValid) |-> (procDone && !busReq));

  assert_shared_on_snoop_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && snoopOp == CMD_READ && snoopHit) |-> sharedOut);

  assert_snoop_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid |-> !procDone);

  assert_victim_then_fill_R10: assert property (@(posedge clk) disable iff (!rstN)
    (procReq && busCmd == CMD_FLUSH && grantOk) |-> !procDone);

endmodule

// File: rtl/mesi_snoop_cache.sv
module mesi_snoop_cache
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procReq,
  input  logic              procWrite,
  input  logic [ADDR_W-1:0] procAddr,
  output logic              procDone,
  output logic [1:0]        procState,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busGrant,
  input  logic              sharedIn,
  output logic              sharedOut,
  input  logic              snoopValid,
  input  logic [1:0]        snoopCmd,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              snoopFlush
);

  localparam int TAG_W = ADDR_W - IDX_W;

  storeStrobe_t     strb;
  lineState_t       lineState, snoopState, resState;
  logic [TAG_W-1:0] lineTag;
  logic             tagHit, snoopHit, victimSel;
  busCmd_t          cmd;

  mesi_tag_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_store (
    .clk(clk), .rstN(rstN),
    .procAddr(procAddr), .snoopAddr(snoopAddr), .strb(strb),
    .procLineState(lineState), .procLineTag(lineTag), .procTagHit(tagHit),
    .snoopLineState(snoopState), .snoopTagHit(snoopHit)
  );

  mesi_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .procReq(procReq), .procWrite(procWrite),
    .lineState(lineState), .tagHit(tagHit),
    .busGrant(busGrant), .sharedIn(sharedIn),
    .snoopValid(snoopValid), .snoopCmd(snoopCmd),
    .snoopState(snoopState), .snoopHit(snoopHit),
    .busReq(busReq), .busCmd(cmd), .victimSel(victimSel),
    .procDone(procDone), .procResState(resState),
    .sharedOut(sharedOut), .snoopFlush(snoopFlush), .strb(strb)
  );

  assign busCmd    = cmd;
  assign procState = resState;
  assign busAddr   = victimSel ? {lineTag, procAddr[IDX_W-1:0]} : procAddr;

endmodule

// File: tb/test_mesi_snoop_cache.sv
`timescale 1ns/1ps
module test_mesi_snoop_cache;

  logic        clk = 0;
  logic        rstN = 0;
  logic        procReq = 0, procWrite = 0;
  logic [15:0] procAddr = '0;
  logic        procDone;
  logic [1:0]  procState;
  logic        busReq;
  logic [1:0]  busCmd;
  logic [15:0] busAddr;
  logic        busGrant = 0, sharedIn = 0;
  logic        sharedOut;
  logic        snoopValid = 0;
  logic [1:0]  snoopCmd = '0;
  logic [15:0] snoopAddr = '0;
  logic        snoopFlush;

  int nTests = 0, nFail = 0;
  logic [1:0] expQ [$];
  string      reqQ [$];

  always #4 clk = ~clk;

  mesi_snoop_cache i_mesi_snoop_cache (
    .clk(clk), .rstN(rstN), .procReq(procReq), .procWrite(procWrite),
    .procAddr(procAddr), .procDone(procDone), .procState(procState),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busGrant(busGrant),
    .sharedIn(sharedIn), .sharedOut(sharedOut), .snoopValid(snoopValid),
    .snoopCmd(snoopCmd), .snoopAddr(snoopAddr), .snoopFlush(snoopFlush)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: every completion pops the expected resulting state (R12)
  always @(negedge clk) begin
    if (rstN && procDone) begin
      if (expQ.size() == 0) check(0, "R12", "unexpected procDone", 1, 0);
      else begin
        logic [1:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(procState == e, r, "procState", procState, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // driver: issue an access, grant every request one cycle after it shows
  task automatic access(input logic w, input logic [15:0] a, input logic sh,
                        input logic [1:0] expSt, input int expN,
                        input logic [1:0] e0, input logic [15:0] ea0,
                        input logic [1:0] e1, input string req);
    logic [1:0]  cmds [4];
    logic [15:0] addr0;
    int n;
    bit done, grantNext;
    n = 0; done = 0; addr0 = '0;
    for (int k = 0; k < 4; k++) cmds[k] = '0;
    expQ.push_back(expSt);
    reqQ.push_back(req);
    procReq = 1; procWrite = w; procAddr = a;
    for (int i = 0; i < 20 && !done; i++) begin
      grantNext = 0;
      @(negedge clk);
      if (procDone) done = 1;
      else if (busReq && !busGrant) begin
        if (n < 4) cmds[n] = busCmd;
        if (n == 0) addr0 = busAddr;
        n++;
        grantNext = 1;
      end
      @(posedge clk); #1;
      busGrant = grantNext;
      sharedIn = grantNext & sh;
      if (done) procReq = 0;
    end
    busGrant = 0; sharedIn = 0; procReq = 0;
    check(done, req, "access completed", done, 1);
    check(n == expN, req, "bus transaction count", n, expN);
    if (expN > 0) begin
      check(cmds[0] == e0, req, "first busCmd", cmds[0], e0);
      check(addr0 == ea0, req, "first busAddr", addr0, ea0);
    end
    if (expN > 1) check(cmds[1] == e1, req, "second busCmd", cmds[1], e1);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [15:0] a,
                       input logic expSh, input logic expFl, input string req);
    snoopValid = 1; snoopCmd = c; snoopAddr = a;
    @(negedge clk);
    check(sharedOut == expSh, req, "sharedOut", sharedOut, expSh);
    check(snoopFlush == expFl, req, "snoopFlush", snoopFlush, expFl);
    @(posedge clk); #1;
    snoopValid = 0; snoopCmd = 0;
  endtask

  localparam logic [15:0] A  = 16'h0012;
  localparam logic [15:0] AX = 16'h0112;
  localparam logic [15:0] C  = 16'h0005;
  localparam logic [15:0] D  = 16'h000D;
  localparam logic [15:0] F  = 16'h0003;

  initial begin
    #(8 * 100000);
    check(0, "WATCHDOG", "run timed out", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    @(negedge clk);
    check(!busReq && !procDone && !sharedOut && !snoopFlush, "R1", "idle outputs", busReq, 0);
    step();
    snoop(2'd1, A, 0, 0, "R1");

    // fills under both shared-line values
    access(0, A, 0, 2'd2, 1, 2'd1, A, 0, "R2");
    access(0, A, 0, 2'd2, 0, 0, 0, 0, "R8");
    snoop(2'd1, A, 1, 0, "R6");
    access(0, A, 0, 2'd1, 0, 0, 0, 0, "R8");
    access(1, A, 0, 2'd3, 1, 2'd2, A, 0, "R5");
    access(0, A, 0, 2'd3, 0, 0, 0, 0, "R8");

    // ignored snoops
    snoop(2'd1, AX, 0, 0, "R11");
    snoop(2'd3, A, 0, 0, "R11");
    access(0, A, 0, 2'd3, 0, 0, 0, 0, "R11");

    snoop(2'd1, A, 1, 1, "R6");
    access(0, A, 0, 2'd1, 0, 0, 0, 0, "R6");

    access(0, C, 1, 2'd1, 1, 2'd1, C, 0, "R2");
    access(1, C, 0, 2'd3, 1, 2'd2, C, 0, "R5");
    snoop(2'd2, C, 0, 1, "R7");
    access(0, C, 0, 2'd2, 1, 2'd1, C, 0, "R7");
    access(1, C, 0, 2'd3, 0, 0, 0, 0, "R4");

    // dirty victim: writeback then fill
    access(0, D, 0, 2'd2, 2, 2'd3, C, 2'd1, "R10");
    snoop(2'd2, D, 0, 0, "R7");
    access(0, D, 0, 2'd2, 1, 2'd1, D, 0, "R7");
    access(1, F, 0, 2'd3, 1, 2'd2, F, 0, "R5");

    // snoop read and local store to an Exclusive line in one cycle
    procReq = 1; procWrite = 1; procAddr = D;
    snoopValid = 1; snoopCmd = 2'd1; snoopAddr = D;
    @(negedge clk);
    check(!procDone, "R9", "procDone during snoop", procDone, 0);
    check(sharedOut, "R9", "sharedOut during snoop", sharedOut, 1);
    step();
    snoopValid = 0; snoopCmd = 0;
    @(negedge clk);
    check(busReq && busCmd == 2'd2, "R9", "upgrade after downgrade", busCmd, 2);
    expQ.push_back(2'd3); reqQ.push_back("R9");
    step();
    busGrant = 1;
    @(negedge clk);
    check(procDone, "R9", "upgrade completes", procDone, 1);
    step();
    busGrant = 0; procReq = 0;
    step();

    // pending writeback whose victim is taken by a snoop
    procReq = 1; procWrite = 0; procAddr = C;
    @(negedge clk);
    check(busReq && busCmd == 2'd3 && busAddr == D, "R10", "victim flush", busAddr, D);
    step();
    snoopValid = 1; snoopCmd = 2'd2; snoopAddr = D;
    @(negedge clk);
    check(snoopFlush, "R9", "snoop takes victim", snoopFlush, 1);
    step();
    snoopValid = 0; snoopCmd = 0;
    @(negedge clk);
    check(busReq && busCmd == 2'd1 && busAddr == C, "R9", "fill without writeback", busCmd, 1);
    expQ.push_back(2'd1); reqQ.push_back("R9");
    step();
    busGrant = 1; sharedIn = 1;
    @(negedge clk);
    check(procDone, "R2", "shared fill completes", procDone, 1);
    step();
    busGrant = 0; sharedIn = 0; procReq = 0;
    step();
    access(0, C, 0, 2'd1, 0, 0, 0, 0, "R8");

    check(expQ.size() == 0, "R12", "completions outstanding", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule